// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into a circular on-chip RAM while capture is enabled. The incoming words arrive on a valid/ready interface together with a trigger flag. Once a word carrying the trigger has been accepted, a post-trigger counter limits how many more words are kept. When that count runs out, acquisition stops by itself, and the recorded history surrounding the trigger event stays in RAM for software to collect.

Software works through a small register port: a 7-bit address, a 32-bit write value, a write strobe and a read strobe. Each read returns its value one cycle later. The register set covers the following:
- an identity constant;
- the RAM geometry;
- a status word;
- a RAM data window whose read pointer advances by itself;
- both pointers;
- the post-trigger counter;
- a control word.

Back-pressure rules for the stream:
- `tw_ready` is high only while capture is enabled and the word that completes acquisition is not already in flight.
- A word is taken on any clock edge where `tw_valid` and `tw_ready` are both high.
- `tw_data` and `tw_trig` only matter in that cycle.
- The source may hold `tw_valid` high for as long as it likes. After capture stops, no further word is taken.

Top module: `trace_capture_buf`

## Requirements
- R1: Register addresses, with their reset values:

  | Address | Register | Reset value |
  |---|---|---|
  | 0 | identity | constant 0x7C0B0001 |
  | 1 | RAM depth | 2^AW, 16 by default |
  | 2 | RAM width | DW, 32 |
  | 3 | status | 0x8 |
  | 4 | RAM data | — |
  | 5 | read pointer | 0 |
  | 6 | write pointer | 0 |
  | 7 | trigger counter | 0 |
  | 8 | control | 0 |

  Any other address reads 0. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R2: Writes to addresses 0 to 4 are ignored. Writing the RAM data address moves neither pointer.
- R3: Control bit 0 is the enable and control bit 1 is a stored port-mode (demultiplexed) flag. Both read back.
  - Writing control with bit 0 = 1 starts a capture and clears the Full, Triggered and Done flags.
  - Writing bit 0 = 0 stops acceptance at once: `tw_ready` goes low.
- R4: A word accepted at a clock edge is written into RAM at the write pointer on the following edge. The write pointer then advances by one, modulo depth. Software may write the write pointer.
- R5: Status bit 0 (Full) sets when a word is written into the last RAM location. It stays set until the next start.
- R6: Status bit 1 (Triggered) sets at the edge that accepts a word with `tw_trig` high.
- R7: With trigger counter N, exactly max(N,1) words are stored from the trigger word on, the trigger word included. Then:
  - status bit 2 (Done) sets;
  - control bit 0 clears;
  - `tw_ready` stays low.
- R8: Status bit 3 (Empty) is high when no accepted word is waiting to be written. It is high whenever Done is set.
- R9: Each read of the RAM data address returns the entry at the read pointer, then advances the pointer by one modulo depth. Software may write the read pointer.
- R10: The trigger counter reads back its remaining value. It decrements by one for each word stored after the trigger, and stops at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_valid | input | 1 | Trace word offered |
| tw_ready | output | 1 | Trace word will be taken this cycle |
| tw_data | input | DW | Trace word |
| tw_trig | input | 1 | Offered word is the trigger event |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value, valid one cycle after reg_rd |

## Verification
Each result has a fixed cycle at which it becomes visible:
- **Triggered flag:** visible right after the edge that accepts the trigger word.
- **Stored word:** lands in RAM, and moves the write pointer, one edge after the edge that accepts it.
- **Done and the cleared enable:** appear at that same later edge. `tw_ready` drops in the cycle after the final word is accepted, because that word is then waiting in the staging register.

The bench drives inputs and samples outputs on falling edges. Each register read raises `reg_rd` for one cycle and samples `reg_rdata` at the next falling edge. Results are only checked a couple of cycles after a stream has stopped, when the pipeline has drained.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [6:0] {
    RA_IDENT   = 7'd0,
    RA_DEPTH   = 7'd1,
    RA_WIDTH   = 7'd2,
    RA_STATUS  = 7'd3,
    RA_DATA    = 7'd4,
    RA_RDPTR   = 7'd5,
    RA_WRPTR   = 7'd6,
    RA_TRIGCNT = 7'd7,
    RA_CTRL    = 7'd8
  } reg_addr_e;

  localparam int ST_FULL  = 0;
  localparam int ST_TRIG  = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_EMPTY = 3;
  localparam int CT_EN    = 0;
  localparam int CT_DEMUX = 1;
endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trc_wr_path.sv
module trc_wr_path #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] in_data,
  input  logic          in_trig,
  input  logic          sw_wr_ptr,
  input  logic [AW-1:0] sw_ptr_val,
  input  logic          restart,
  output logic          stage_vld,
  output logic          stage_trig,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic          full
);
  localparam logic [AW-1:0] LAST_LOC = '1;

  logic [DW-1:0] stage_data;

  // one staging register between acceptance and the RAM write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_vld  <= 1'b0;
      stage_trig <= 1'b0;
      stage_data <= '0;
    end else begin
      stage_vld <= accept;
      if (accept) begin
        stage_data <= in_data;
        stage_trig <= in_trig;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (sw_wr_ptr) begin
      wr_ptr <= sw_ptr_val;
    end else if (stage_vld) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else if (restart) begin
      full <= 1'b0;
    end else if (stage_vld && (wr_ptr == LAST_LOC)) begin
      full <= 1'b1;
    end
  end

  assign ram_we    = stage_vld;
  assign ram_waddr = wr_ptr;
  assign ram_wdata = stage_data;
endmodule

// File: rtl/trc_acq_ctrl.sv
module trc_acq_ctrl #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          in_trig,
  input  logic          stage_vld,
  input  logic          stage_trig,
  input  logic          sw_wr_ctrl,
  input  logic          sw_wr_cnt,
  input  logic [CW-1:0] wdata,
  output logic          en,
  output logic          demux,
  output logic          triggered,
  output logic          done,
  output logic [CW-1:0] cnt,
  output logic          stop_pending
);
  logic post_word;
  logic last_word;

  // a stored word counts once the trigger word itself is in the stage
  assign post_word    = stage_vld && (stage_trig || triggered);
  assign last_word    = post_word && (cnt <= CW'(1));
  assign stop_pending = last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      demux     <= 1'b0;
      triggered <= 1'b0;
      done      <= 1'b0;
    end else if (sw_wr_ctrl) begin
      en    <= wdata[0];
      demux <= wdata[1];
      if (wdata[0]) begin
        triggered <= 1'b0;
        done      <= 1'b0;
      end
    end else begin
      if (last_word) begin
        en   <= 1'b0;
        done <= 1'b1;
      end
      if (accept && in_trig) triggered <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sw_wr_cnt) begin
      cnt <= wdata;
    end else if (post_word) begin
      cnt <= (cnt <= CW'(1)) ? '0 : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/trc_reg_bank.sv
module trc_reg_bank
  import trc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 4,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] wptr_val,
  input  logic [3:0]    status,
  input  logic [1:0]    ctrl,
  input  logic [AW-1:0] wr_ptr,
  input  logic [31:0]   cnt,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] rd_ptr,
  output logic          sw_wr_ctrl,
  output logic          sw_wr_cnt,
  output logic          sw_wr_wrptr,
  output logic [31:0]   reg_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] rd_mux;
  logic        data_pop;

  assign sw_wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign sw_wr_cnt   = reg_wr && (reg_addr == RA_TRIGCNT);
  assign sw_wr_wrptr = reg_wr && (reg_addr == RA_WRPTR);
  assign data_pop    = reg_rd && (reg_addr == RA_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (reg_wr && (reg_addr == RA_RDPTR)) begin
      rd_ptr <= wptr_val;
    end else if (data_pop) begin
      rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_IDENT:   rd_mux = ID_VALUE;
      RA_DEPTH:   rd_mux = 32'(DEPTH);
      RA_WIDTH:   rd_mux = 32'(DW);
      RA_STATUS:  rd_mux[3:0] = status;
      RA_DATA:    rd_mux[DW-1:0] = ram_rdata;
      RA_RDPTR:   rd_mux[AW-1:0] = rd_ptr;
      RA_WRPTR:   rd_mux[AW-1:0] = wr_ptr;
      RA_TRIGCNT: rd_mux = cnt;
      RA_CTRL:    rd_mux[1:0] = ctrl;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 4,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tw_valid,
  output logic          tw_ready,
  input  logic [DW-1:0] tw_data,
  input  logic          tw_trig,
  input  logic [6:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);
  logic          accept;
  logic          stage_vld, stage_trig;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, rd_ptr, wr_ptr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          full, acq_en, demux, triggered, done, stop_pending;
  logic [31:0]   cnt;
  logic          sw_wr_ctrl, sw_wr_cnt, sw_wr_wrptr;
  logic          restart;
  logic [3:0]    status;

  assign tw_ready = acq_en && !stop_pending;
  assign accept   = tw_valid && tw_ready;
  assign restart  = sw_wr_ctrl && reg_wdata[CT_EN];

  always_comb begin
    status           = '0;
    status[ST_FULL]  = full;
    status[ST_TRIG]  = triggered;
    status[ST_DONE]  = done;
    status[ST_EMPTY] = !stage_vld;
  end

  trc_wr_path #(.DW(DW), .AW(AW)) u_wr (
    .clk, .rst_n, .accept,
    .in_data(tw_data), .in_trig(tw_trig),
    .sw_wr_ptr(sw_wr_wrptr), .sw_ptr_val(reg_wdata[AW-1:0]),
    .restart, .stage_vld, .stage_trig,
    .ram_we, .ram_waddr, .ram_wdata, .wr_ptr, .full
  );

  trc_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk, .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_ptr), .rdata(ram_rdata)
  );

  trc_acq_ctrl #(.CW(32)) u_acq (
    .clk, .rst_n, .accept, .in_trig(tw_trig),
    .stage_vld, .stage_trig, .sw_wr_ctrl, .sw_wr_cnt,
    .wdata(reg_wdata), .en(acq_en), .demux, .triggered, .done,
    .cnt, .stop_pending
  );

  trc_reg_bank #(.DW(DW), .AW(AW), .ID_VALUE(ID_VALUE)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd,
    .wptr_val(reg_wdata[AW-1:0]), .status, .ctrl({demux, acq_en}),
    .wr_ptr, .cnt, .ram_rdata, .rd_ptr,
    .sw_wr_ctrl, .sw_wr_cnt, .sw_wr_wrptr, .reg_rdata
  );
endmodule

// File: rtl/trace_capture_buf_chk.sv
module trace_capture_buf_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tw_ready,
  input logic          acq_en,
  input logic          done,
  input logic          full,
  input logic          stage_vld,
  input logic          restart,
  input logic          sw_wr_wrptr,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [6:0]    reg_addr
);
  AST_DONE_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tw_ready); // R7

  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tw_ready |-> acq_en); // R3

  AST_WRPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_vld && !sw_wr_wrptr) |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1))); // R4

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !restart) |=> full); // R5

  AST_EMPTY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stage_vld); // R8

  AST_RDPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 7'd4 && !(reg_wr && reg_addr == 7'd5))
      |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1))); // R9
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tw_ready(tw_ready), .acq_en(acq_en),
  .done(done), .full(full), .stage_vld(stage_vld), .restart(restart),
  .sw_wr_wrptr(sw_wr_wrptr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tw_valid = 1'b0;
  logic        tw_ready;
  logic [31:0] tw_data = '0;
  logic        tw_trig = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  trace_capture_buf #(.DW(DW), .AW(AW)) u_trace_capture_buf (
    .clk, .rst_n, .tw_valid, .tw_ready, .tw_data, .tw_trig,
    .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata
  );

  function automatic logic [31:0] wd(int n);
    return 32'hC300_0000 ^ (32'(n) * 32'h0001_0F07);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // offers words until ready drops or maxw words were taken; trigger on word k
  task automatic stream(int k, int maxw, output int taken);
    taken = 0;
    while (taken < maxw) begin
      @(negedge clk);
      if (!tw_ready) break;
      tw_valid = 1'b1; tw_data = wd(taken); tw_trig = (taken == k);
      @(posedge clk);
      taken++;
    end
    @(negedge clk);
    tw_valid = 1'b0; tw_trig = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_capture(int s, int k, int n);
    logic [31:0] v;
    int taken, expn, base, cnt_rd;
    expn = k + ((n == 0) ? 1 : n);
    reg_write(6, 32'(s));
    reg_write(7, 32'(n));
    reg_write(8, 32'h1);
    stream(k, 200, taken);
    chk("R7 words taken", 32'(taken), 32'(expn));
    chk("R7 ready low after done", {31'b0, tw_ready}, 32'h0);
    reg_read(3, v);
    chk("R5 R6 R7 R8 status", v,
        {28'b0, 1'b1, 1'b1, 1'b1, ((s + expn) >= DEPTH) ? 1'b1 : 1'b0});
    reg_read(8, v);
    chk("R7 enable cleared", v, 32'h0);
    reg_read(6, v);
    chk("R4 write pointer", v, 32'((s + expn) % DEPTH));
    reg_read(7, v);
    chk("R10 counter exhausted", v, 32'h0);
    if (expn <= DEPTH) begin base = s; cnt_rd = expn; end
    else begin base = (s + expn) % DEPTH; cnt_rd = DEPTH; end
    reg_write(5, 32'(base));
    for (int j = 0; j < cnt_rd; j++) begin
      reg_read(4, v);
      chk("R9 RAM data", v, wd(expn - cnt_rd + j));
    end
    reg_read(5, v);
    chk("R9 read pointer wrap", v, 32'((base + cnt_rd) % DEPTH));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int taken;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and geometry
    reg_read(0, v); chk("R1 identity", v, 32'h7C0B_0001);
    reg_read(1, v); chk("R1 depth", v, 32'(DEPTH));
    reg_read(2, v); chk("R1 width", v, 32'(DW));
    reg_read(3, v); chk("R1 status reset", v, 32'h8);
    reg_read(5, v); chk("R1 read pointer reset", v, 32'h0);
    reg_read(6, v); chk("R1 write pointer reset", v, 32'h0);
    reg_read(7, v); chk("R1 counter reset", v, 32'h0);
    reg_read(8, v); chk("R1 control reset", v, 32'h0);
    reg_read(9, v); chk("R1 unmapped reads zero", v, 32'h0);
    chk("R1 ready low at reset", {31'b0, tw_ready}, 32'h0);

    // R2 read-only registers ignore writes
    for (int a = 0; a <= 4; a++) reg_write(a, 32'hFFFF_FFFF);
    reg_read(0, v); chk("R2 identity kept", v, 32'h7C0B_0001);
    reg_read(1, v); chk("R2 depth kept", v, 32'(DEPTH));
    reg_read(2, v); chk("R2 width kept", v, 32'(DW));
    reg_read(3, v); chk("R2 status kept", v, 32'h8);
    reg_read(5, v); chk("R2 read pointer kept", v, 32'h0);
    reg_read(6, v); chk("R2 write pointer kept", v, 32'h0);

    // R3 mode bit stored, enable gates ready
    reg_write(8, 32'h2);
    reg_read(8, v); chk("R3 demux readback", v, 32'h2);
    chk("R3 ready low while disabled", {31'b0, tw_ready}, 32'h0);
    reg_write(8, 32'h3);
    chk("R3 ready high when enabled", {31'b0, tw_ready}, 32'h1);

    // R10 partial countdown, then R3 stop by software
    reg_write(6, 32'h0);
    reg_write(7, 32'd9);
    reg_write(8, 32'h1);
    stream(1, 4, taken);
    reg_read(7, v); chk("R10 counter after 3 stored", v, 32'd6);
    reg_read(3, v); chk("R6 R8 triggered not done", v, 32'hA);
    reg_write(8, 32'h0);
    chk("R3 ready low after stop", {31'b0, tw_ready}, 32'h0);
    reg_read(3, v); chk("R3 stop does not mark done", v, 32'hA);
    reg_write(8, 32'h1);
    reg_read(3, v); chk("R3 start clears flags", v, 32'h8);
    reg_write(8, 32'h0);

    // sweep of trigger position, post-trigger count and start location
    for (int k = 0; k < 6; k++)
      for (int n = 0; n < 7; n++)
        run_capture((k * 5 + n * 3) % DEPTH, k, n);

    // long capture that wraps the RAM
    run_capture(2, 20, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule